// File: doc/BRIEF.md
# Chained-Command Serial Register Port

This block is a serial slave that gives a host processor read and write access to a bank of 32 internal 24-bit registers. It uses four wires: an active-low select, a bit clock, a data input and a data output. Every transaction opens with an 8-bit command byte. A write command is followed by 24 data bits. A read command makes the port shift the addressed register out, most significant bit first.

While a read is in progress, the host keeps clocking bytes in on the data input. Each complete byte is decoded as a new command and is acted on at once. The host can therefore drop the rest of a register after any whole byte and start the next access without a pause. A dedicated sync byte lets a read run to completion. A control byte requests a soft reset, which clears the register bank and pulses an output strobe.

All port logic runs on the system clock. The select, bit clock and data input are oversampled through synchronizers, so the bit clock must be several times slower than the system clock. The output enable is a separate port, and the pad-level tri-state buffer is built from it outside this block.

Top module: `rp_top`

## Requirements
- R1: After a synchronous reset, `sdo_en`, `sdo` and `soft_rst` are low, and every register reads back as 0.
- R2: Command bytes are received MSB first. When bit 7 is 0 the byte is a register access: bit 6 is 1 for a write and 0 for a read, and bits 5:1 are the address. An access byte with bit 0 set is ignored.
- R3: A write command takes the next 24 input bits, MSB first, as the new register value. After the 24th bit the port waits for a command byte again.
- R4: Read data is presented MSB first. The first data bit is valid before the first data-phase rising edge, and each later bit changes only on a falling edge of the bit clock.
- R5: A read may be ended at any byte boundary by raising the select, and the next transaction then works normally.
- R6: During a read, any completed input byte other than the sync byte is executed immediately. A read command restarts the output with the new register, and a write command ends the read and collects 24 data bits.
- R7: The sync byte 0xFE received during a read does not disturb the output. After 24 data bits have been shifted out, the port waits for a command byte.
- R8: While the select is high, `sdo_en` and `sdo` are low, within three system clocks of the select rising.
- R9: Bit-clock edges while the select is high are ignored. A select rising edge discards any partial command or partial write data.
- R10: With the select held low for the whole time (three-wire use), back-to-back transactions decode correctly.
- R11: Command 0x80 gives a single-cycle `soft_rst` pulse and returns every register to 0.
- R12: Control bytes (bit 7 = 1) other than 0x80 and 0xFE have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial bit clock from the host (mode 0) |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_en | output | 1 | Enable for the external data-output driver |
| soft_rst | output | 1 | One-cycle strobe on a soft-reset command |

## Verification
A table of writes is applied to registers whose values include all ones, a lone MSB, a lone LSB and mixed patterns. Every value is then read back in full, which separates bit-order and shift-count errors from addressing errors. Directed sequences cover the remaining read behaviour: reads cut after one byte, reads chained into a second read or into a write, and an observation on either side of a clock edge that tells a rising-edge change from a falling-edge change. Further sequences send partial writes aborted by the select, clock edges with the select high, malformed or unknown command bytes, and a soft reset. Each of these is checked by reading back a register it could have corrupted.

// File: rtl/rp_pkg.sv
package rp_pkg;

  localparam int ADDR_W = 5;
  localparam logic [7:0] CMD_SYNC = 8'hFE;
  localparam logic [7:0] CMD_SRST = 8'h80;

  typedef enum logic [1:0] {
    ST_CMD = 2'd0,
    ST_WR  = 2'd1,
    ST_RD  = 2'd2
  } port_state_e;

  typedef enum logic [2:0] {
    K_READ  = 3'd0,
    K_WRITE = 3'd1,
    K_SRST  = 3'd2,
    K_SYNC  = 3'd3,
    K_OTHER = 3'd4
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [7:0] b);
    cmd_kind_e k;
    if (b == CMD_SYNC)      k = K_SYNC;
    else if (b == CMD_SRST) k = K_SRST;
    else if (b[7] || b[0])  k = K_OTHER;
    else if (b[6])          k = K_WRITE;
    else                    k = K_READ;
    return k;
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_addr(input logic [7:0] b);
    return b[ADDR_W:1];
  endfunction

endpackage

// File: rtl/rp_sync.sv
module rp_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rp_regbank.sv
module rp_regbank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]  valid;
  logic              vld_q;

  // plain array with one write and one registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  // per-entry valid flags make a clear cost one cycle
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid <= '0;
      vld_q <= 1'b0;
    end else begin
      if (we) valid[waddr] <= 1'b1;
      vld_q <= valid[raddr];
    end
  end

  assign rdata = vld_q ? mem_q : '0;
endmodule

// File: rtl/rp_engine.sv
module rp_engine
  import rp_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              soft_rst,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int NBYTES = DATA_W / 8;
  localparam int BC_W   = $clog2(NBYTES + 1);
  localparam int WC_W   = $clog2(DATA_W);

  port_state_e       state;
  logic              sclk_d;
  logic [6:0]        in_sr;
  logic [2:0]        in_cnt;
  logic [DATA_W-2:0] wr_sr;
  logic [WC_W-1:0]   wr_cnt;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] out_sr;
  logic [1:0]        load_pipe;
  logic              skip_fall;
  logic [BC_W-1:0]   bytes_left;

  logic       rise, fall, byte_done;
  logic [7:0] rx_byte;
  cmd_kind_e  kind;

  assign rise      = !cs_n_s && sclk_s && !sclk_d;
  assign fall      = !cs_n_s && !sclk_s && sclk_d;
  assign rx_byte   = {in_sr, sdi_s};
  assign byte_done = rise && (in_cnt == 3'd7) && (state != ST_WR);
  assign kind      = classify(rx_byte);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_CMD;
      sclk_d     <= 1'b0;
      in_sr      <= '0;
      in_cnt     <= '0;
      wr_sr      <= '0;
      wr_cnt     <= '0;
      tgt_addr   <= '0;
      out_sr     <= '0;
      load_pipe  <= '0;
      skip_fall  <= 1'b0;
      bytes_left <= '0;
      rd_addr    <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      soft_rst   <= 1'b0;
      sdo        <= 1'b0;
      sdo_en     <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      wr_en     <= 1'b0;
      soft_rst  <= 1'b0;
      sdo_en    <= !cs_n_s;
      sdo       <= !cs_n_s && out_sr[DATA_W-1];
      load_pipe <= {load_pipe[0], 1'b0};

      // command byte collection runs in both the command and read phases
      if (rise && state != ST_WR) begin
        in_sr  <= rx_byte[6:0];
        in_cnt <= in_cnt + 3'd1;
      end

      // output bits move on falling edges, except the one right after a load
      if (fall && state == ST_RD) begin
        if (skip_fall) skip_fall <= 1'b0;
        else out_sr <= {out_sr[DATA_W-2:0], 1'b0};
      end

      if (load_pipe[1]) out_sr <= rd_data;

      if (rise && state == ST_WR) begin
        wr_sr <= {wr_sr[DATA_W-3:0], sdi_s};
        if (wr_cnt == WC_W'(DATA_W - 1)) begin
          wr_en   <= 1'b1;
          wr_addr <= tgt_addr;
          wr_data <= {wr_sr, sdi_s};
          wr_cnt  <= '0;
          state   <= ST_CMD;
        end else begin
          wr_cnt <= wr_cnt + WC_W'(1);
        end
      end

      if (byte_done) begin
        unique case (kind)
          K_READ: begin
            rd_addr    <= cmd_addr(rx_byte);
            load_pipe  <= 2'b01;
            skip_fall  <= 1'b1;
            bytes_left <= BC_W'(NBYTES);
            state      <= ST_RD;
          end
          K_WRITE: begin
            tgt_addr <= cmd_addr(rx_byte);
            wr_cnt   <= '0;
            out_sr   <= '0;
            state    <= ST_WR;
          end
          K_SRST: begin
            soft_rst <= 1'b1;
            out_sr   <= '0;
            state    <= ST_CMD;
          end
          default: begin
            if (state == ST_RD) begin
              bytes_left <= bytes_left - BC_W'(1);
              if (bytes_left <= BC_W'(1)) state <= ST_CMD;
            end
          end
        endcase
      end

      // deselect discards everything in flight
      if (cs_n_s) begin
        state      <= ST_CMD;
        in_cnt     <= '0;
        wr_cnt     <= '0;
        out_sr     <= '0;
        load_pipe  <= '0;
        skip_fall  <= 1'b0;
        bytes_left <= '0;
      end
    end
  end
endmodule

// File: rtl/rp_top.sv
module rp_top
  import rp_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en,
  output logic soft_rst
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              wr_en;

  rp_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({sdi, cs_n, sclk}),
    .q  (pins_s)
  );

  rp_engine #(.DATA_W(DATA_W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (pins_s[0]),
    .cs_n_s  (pins_s[1]),
    .sdi_s   (pins_s[2]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .soft_rst(soft_rst),
    .sdo     (sdo),
    .sdo_en  (sdo_en)
  );

  rp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .clr  (soft_rst),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/rp_checker.sv
module rp_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sdo,
  input logic sdo_en,
  input logic soft_rst,
  input logic wr_en
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R8: deselect held for three clocks turns the driver off
  assert_oe_off_deselected_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_en);

  // R8: no data while the driver is off
  assert_sdo_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !sdo_en |-> !sdo);

  // R3: a completed write commits in a single cycle
  assert_write_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R11: soft reset strobe lasts one cycle
  assert_srst_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  // R11: soft reset and a register write never coincide
  assert_no_write_with_srst_R11: assert property (@(posedge clk) disable iff (rst)
    !(soft_rst && wr_en));
endmodule

bind rp_top rp_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_n    (cs_n),
  .sdo     (sdo),
  .sdo_en  (sdo_en),
  .soft_rst(soft_rst),
  .wr_en   (wr_en)
);

// File: tb/tb_rp_top.sv
module tb_rp_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;

  // {address, value}
  localparam logic [28:0] VEC [NVEC] = '{
    {5'd0,  24'hA55A3C},
    {5'd31, 24'hFFFFFF},
    {5'd1,  24'h000001},
    {5'd17, 24'h800000},
    {5'd10, 24'h123456},
    {5'd5,  24'hC30FF0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_en, soft_rst;

  int n_chk = 0;
  int n_err = 0;
  int srst_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rp_top dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .soft_rst(soft_rst)
  );

  always @(posedge clk) if (!rst && soft_rst) srst_cnt++;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sdi = tx[i];
      wait_clk(HALF);
      rx[i] = sdo;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  function automatic logic [7:0] rd_cmd(input logic [4:0] a);
    return {2'b00, a, 1'b0};
  endfunction

  function automatic logic [7:0] wr_cmd(input logic [4:0] a);
    return {2'b01, a, 1'b0};
  endfunction

  task automatic send_word(input logic [23:0] v);
    logic [7:0] rx;
    xbyte(v[23:16], rx);
    xbyte(v[15:8], rx);
    xbyte(v[7:0], rx);
  endtask

  task automatic recv_word(output logic [23:0] v);
    logic [7:0] rx;
    xbyte(8'hFE, rx); v[23:16] = rx;
    xbyte(8'hFE, rx); v[15:8]  = rx;
    xbyte(8'hFE, rx); v[7:0]   = rx;
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [23:0] v);
    logic [7:0] rx;
    sel;
    xbyte(wr_cmd(a), rx);
    send_word(v);
    desel;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [23:0] v);
    logic [7:0] rx;
    sel;
    xbyte(rd_cmd(a), rx);
    recv_word(v);
    desel;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [7:0]  rx;

    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);

    // R1 reset state
    check("R1 sdo_en", {31'd0, sdo_en}, 32'd0);
    check("R1 sdo", {31'd0, sdo}, 32'd0);
    check("R1 soft_rst", {31'd0, soft_rst}, 32'd0);
    rd_reg(5'd7, v);
    check("R1 unwritten reg", {8'd0, v}, 32'd0);

    // R3 R4 table: write all, then read all
    for (int i = 0; i < NVEC; i++) wr_reg(VEC[i][28:24], VEC[i][23:0]);
    for (int i = 0; i < NVEC; i++) begin
      rd_reg(VEC[i][28:24], v);
      check("R3 R4 write/readback", {8'd0, v}, {8'd0, VEC[i][23:0]});
    end

    // R8 driver enable follows select
    sel;
    check("R8 sdo_en selected", {31'd0, sdo_en}, 32'd1);
    desel;
    check("R8 sdo_en deselected", {31'd0, sdo_en}, 32'd0);
    check("R8 sdo deselected", {31'd0, sdo}, 32'd0);

    // R4 first bit before first rise, change only on the falling edge
    sel;
    xbyte(rd_cmd(5'd17), rx);
    wait_clk(HALF);
    check("R4 first bit ready", {31'd0, sdo}, 32'd1);
    sclk = 1'b1;
    wait_clk(HALF - 1);
    check("R4 held through rise", {31'd0, sdo}, 32'd1);
    wait_clk(1);
    sclk = 1'b0;
    wait_clk(HALF);
    check("R4 changed after fall", {31'd0, sdo}, 32'd0);
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
    desel;

    // R5 read cut after one byte, then a normal read
    sel;
    xbyte(rd_cmd(5'd0), rx);
    xbyte(8'hFE, rx);
    check("R5 truncated byte", {24'd0, rx}, 32'hA5);
    desel;
    rd_reg(5'd10, v);
    check("R5 read after truncation", {8'd0, v}, 32'h123456);

    // R6 read chained into read
    sel;
    xbyte(rd_cmd(5'd10), rx);
    xbyte(rd_cmd(5'd17), rx);
    check("R6 first read top byte", {24'd0, rx}, 32'h12);
    recv_word(v);
    check("R6 chained read", {8'd0, v}, 32'h800000);
    desel;

    // R6 read chained into write
    sel;
    xbyte(rd_cmd(5'd0), rx);
    xbyte(wr_cmd(5'd20), rx);
    check("R6 read before write", {24'd0, rx}, 32'hA5);
    send_word(24'h0BEEF1);
    desel;
    rd_reg(5'd20, v);
    check("R6 chained write", {8'd0, v}, 32'h0BEEF1);

    // R9 partial write aborted by deselect
    sel;
    xbyte(wr_cmd(5'd5), rx);
    xbyte(8'h11, rx);
    xbyte(8'h22, rx);
    desel;
    rd_reg(5'd5, v);
    check("R9 aborted write", {8'd0, v}, 32'hC30FF0);

    // R9 edges while deselected are ignored
    xbyte(wr_cmd(5'd5), rx);
    send_word(24'h333333);
    wait_clk(2 * HALF);
    rd_reg(5'd5, v);
    check("R9 edges while deselected", {8'd0, v}, 32'hC30FF0);

    // R2 access byte with bit 0 set is ignored
    sel;
    xbyte(8'h47, rx);
    send_word(24'hFEFEFE);
    desel;
    rd_reg(5'd3, v);
    check("R2 malformed access", {8'd0, v}, 32'd0);

    // R12 unknown control byte, then a read in the same frame
    sel;
    xbyte(8'h90, rx);
    xbyte(rd_cmd(5'd1), rx);
    recv_word(v);
    desel;
    check("R12 read after unknown control", {8'd0, v}, 32'h000001);
    check("R12 no soft reset", srst_cnt, 32'd0);

    // R10 R7 three-wire: select never released between transactions
    sel;
    xbyte(wr_cmd(5'd12), rx);
    send_word(24'h5A5A5A);
    xbyte(rd_cmd(5'd12), rx);
    recv_word(v);
    check("R10 three-wire readback", {8'd0, v}, 32'h5A5A5A);
    xbyte(rd_cmd(5'd31), rx);
    recv_word(v);
    check("R7 full read through sync bytes", {8'd0, v}, 32'hFFFFFF);
    xbyte(rd_cmd(5'd1), rx);
    recv_word(v);
    check("R7 command accepted after read", {8'd0, v}, 32'h000001);
    desel;

    // R11 soft reset
    sel;
    xbyte(8'h80, rx);
    desel;
    check("R11 soft_rst pulse count", srst_cnt, 32'd1);
    rd_reg(5'd10, v);
    check("R11 reg cleared", {8'd0, v}, 32'd0);
    rd_reg(5'd20, v);
    check("R11 reg cleared 2", {8'd0, v}, 32'd0);
    wr_reg(5'd9, 24'h00FF00);
    rd_reg(5'd9, v);
    check("R11 writable after reset", {8'd0, v}, 32'h00FF00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule